// File: doc/BRIEF.md
# Modem Mode Control Register

This block holds the eight-bit mode byte of a packet modem data pump and drives the control lines that follow from it. The host processor writes the byte with a single strobe. There is no readback. The stored bits then decide six things: the interrupt pin, the inversion of the transmit and receive data paths, the direction of the modem, the scrambler reset, the power-save gating, and whether data-quality readings raise an interrupt.

Some writes act over time as well as setting levels. A write that flips the direction bit sends a one-cycle cancel pulse to the task engine. Two kinds of write start a settle window: a write that moves the modem from receive to transmit, and a write that leaves power-save. A small state machine with states READY, SETTLE_A and SETTLE_B runs this window. A settle-triggering write moves it from any state to SETTLE_A. The first bit-rate tick moves it from SETTLE_A to SETTLE_B, and the second tick moves it from SETTLE_B back to READY. While the machine is outside READY, new task requests are held off.

Top module: `modem_mode_ctrl`

## Requirements
- R1: After reset the stored mode is all zeros. This gives receive mode (`tx_mode`=0), `pwr_save`=0, `irq_n`=1, `settle_busy`=0, `scr_hold`=1 and uninverted data, and the interrupt and data-quality flags are 0.
- R2: Field positions in `wr_data` are: bit 7 interrupt pin enable, bit 6 data inversion, bit 5 direction (1 = transmit), bit 4 scrambler enable, bit 3 power-save, bit 2 data-quality interrupt enable. Bits 1 and 0 are stored as zero and have no effect. The new value is visible on the outputs in the cycle after the write edge.
- R3: `irq_n` is 0 exactly when the pin enable bit is 1 and `irq_flag` is 1. Otherwise it is 1.
- R4: When the inversion bit is 1, `tx_out` = ~`tx_in` and `rx_out` = ~`rx_in`. When it is 0, both paths pass the data unchanged. The change applies from the cycle after the write.
- R5: A write that changes bit 5 makes `task_cancel` high for exactly the one cycle after the write edge. A write that leaves bit 5 unchanged gives no pulse.
- R6: A write that sets bit 5 from 0 to 1, or that clears bit 3 from 1 to 0, raises `settle_busy` from the cycle after the write. `settle_busy` stays high until the second `bit_tick` sampled after that write, and falls in the cycle after that tick. Leaving transmit mode or entering power-save does not raise it.
- R7: `task_start` equals `task_req` while `settle_busy` is 0, and is 0 while `settle_busy` is 1.
- R8: `scr_hold` is 0 only when the scrambler enable bit is 1 and `task_code` is 1 (scrambled sequence transmit), 2 (receive data block) or 3 (transmit data block). For every other code it is 1.
- R9: In receive mode with bit 2 set, a `dq_ready` pulse sets `irq_flag` and `dqrdy_flag` in the next cycle. In transmit mode, or with bit 2 clear, the pulse has no effect. `stat_rd` clears both flags. A set in the same cycle as `stat_rd` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode byte write strobe |
| wr_data | input | 8 | Mode byte |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| task_code | input | 3 | Code of the current task |
| task_req | input | 1 | New task request |
| dq_ready | input | 1 | New data-quality reading pulse |
| stat_rd | input | 1 | Status read strobe, clears flags |
| tx_in | input | 1 | Transmit data bit before inversion |
| rx_in | input | 1 | Receive data bit before inversion |
| tx_out | output | 1 | Transmit data bit after inversion |
| rx_out | output | 1 | Receive data bit after inversion |
| tx_mode | output | 1 | 1 = transmit, 0 = receive |
| pwr_save | output | 1 | Power-save gate for filters, clock recovery and output buffer |
| scr_hold | output | 1 | Scrambler reset hold |
| task_cancel | output | 1 | One-cycle cancel pulse on direction change |
| task_start | output | 1 | Task request accepted |
| settle_busy | output | 1 | Settle window active |
| irq_flag | output | 1 | Status interrupt flag |
| dqrdy_flag | output | 1 | Status data-quality ready flag |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
A wrong stored mode bit shows at the ports one cycle after the write: on `tx_mode`, `pwr_save`, the inverted data, `scr_hold` or `irq_n`. The bench sweeps every field to find it. A settle machine stuck in a state, or one that takes the wrong number of ticks, shows as `settle_busy` and `task_start` being wrong at a known tick count after the triggering write. A flag that sets in the wrong mode shows in the cycle after the `dq_ready` pulse, on the flags and the pin together.

// File: rtl/modem_mode_pkg.sv
package modem_mode_pkg;
    localparam int MODE_W = 8;
    localparam int TASK_W = 3;

    localparam logic [TASK_W-1:0] TASK_SEQ_TX = 3'd1;
    localparam logic [TASK_W-1:0] TASK_BLK_RX = 3'd2;
    localparam logic [TASK_W-1:0] TASK_BLK_TX = 3'd3;

    typedef struct packed {
        logic       irq_pin_en;
        logic       invert;
        logic       txmode;
        logic       scr_en;
        logic       psave;
        logic       dq_irq_en;
        logic [1:0] rsvd;
    } mode_t;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_SETTLE_A = 2'd1,
        ST_SETTLE_B = 2'd2
    } settle_st_e;
endpackage

// File: rtl/modem_mode_reg.sv
module modem_mode_reg
    import modem_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    output mode_t             mode_q,
    output logic              cancel_q,
    output logic              settle_trig
);
    mode_t mode_nxt;

    always_comb begin
        mode_nxt      = mode_t'(wr_data);
        mode_nxt.rsvd = '0;
        settle_trig   = wr_en & ((~mode_q.txmode & mode_nxt.txmode) |
                                 (mode_q.psave & ~mode_nxt.psave));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            cancel_q <= 1'b0;
        end else begin
            cancel_q <= wr_en & (mode_nxt.txmode != mode_q.txmode);
            if (wr_en) begin
                mode_q <= mode_nxt;
            end
        end
    end
endmodule

// File: rtl/modem_settle_fsm.sv
module modem_settle_fsm
    import modem_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic bit_tick,
    output logic busy
);
    settle_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (trig) begin
            state_d = ST_SETTLE_A;
        end else begin
            unique case (state_q)
                ST_READY:    state_d = ST_READY;
                ST_SETTLE_A: if (bit_tick) state_d = ST_SETTLE_B;
                ST_SETTLE_B: if (bit_tick) state_d = ST_READY;
                default:     state_d = ST_READY;
            endcase
        end
    end

    always_comb begin
        busy = (state_q != ST_READY);
    end
endmodule

// File: rtl/modem_irq_flags.sv
module modem_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic dq_ready,
    input  logic rx_mode,
    input  logic dq_irq_en,
    input  logic stat_rd,
    output logic irq_q,
    output logic dqrdy_q
);
    logic set_flags;

    always_comb begin
        set_flags = dq_ready & rx_mode & dq_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            dqrdy_q <= 1'b0;
        end else if (set_flags) begin
            irq_q   <= 1'b1;
            dqrdy_q <= 1'b1;
        end else if (stat_rd) begin
            irq_q   <= 1'b0;
            dqrdy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/modem_mode_ctrl.sv
module modem_mode_ctrl
    import modem_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              bit_tick,
    input  logic [TASK_W-1:0] task_code,
    input  logic              task_req,
    input  logic              dq_ready,
    input  logic              stat_rd,
    input  logic              tx_in,
    input  logic              rx_in,
    output logic              tx_out,
    output logic              rx_out,
    output logic              tx_mode,
    output logic              pwr_save,
    output logic              scr_hold,
    output logic              task_cancel,
    output logic              task_start,
    output logic              settle_busy,
    output logic              irq_flag,
    output logic              dqrdy_flag,
    output logic              irq_n
);
    mode_t mode_q;
    logic  settle_trig;
    logic  scr_task;

    modem_mode_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .mode_q      (mode_q),
        .cancel_q    (task_cancel),
        .settle_trig (settle_trig)
    );

    modem_settle_fsm u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (settle_trig),
        .bit_tick (bit_tick),
        .busy     (settle_busy)
    );

    modem_irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .dq_ready  (dq_ready),
        .rx_mode   (~mode_q.txmode),
        .dq_irq_en (mode_q.dq_irq_en),
        .stat_rd   (stat_rd),
        .irq_q     (irq_flag),
        .dqrdy_q   (dqrdy_flag)
    );

    always_comb begin
        scr_task   = (task_code == TASK_SEQ_TX) | (task_code == TASK_BLK_RX) |
                     (task_code == TASK_BLK_TX);
        scr_hold   = ~(mode_q.scr_en & scr_task);
        tx_out     = tx_in ^ mode_q.invert;
        rx_out     = rx_in ^ mode_q.invert;
        tx_mode    = mode_q.txmode;
        pwr_save   = mode_q.psave;
        task_start = task_req & ~settle_busy;
        irq_n      = ~(mode_q.irq_pin_en & irq_flag);
    end
endmodule

// File: rtl/modem_mode_chk.sv
module modem_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] task_code,
    input logic       dq_ready,
    input logic       task_cancel,
    input logic       settle_busy,
    input logic       task_start,
    input logic       irq_n,
    input logic       irq_flag,
    input logic       scr_hold
);
    assert_cancel_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        task_cancel |=> !task_cancel);

    assert_cancel_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(task_cancel) |-> $past(wr_en));

    assert_busy_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settle_busy) |-> $past(wr_en));

    assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        settle_busy |-> !task_start);

    assert_pin_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> irq_flag);

    assert_flag_after_dq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(dq_ready));

    assert_scr_task_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_hold |-> (task_code == 3'd1 || task_code == 3'd2 || task_code == 3'd3));
endmodule

bind modem_mode_ctrl modem_mode_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .task_code   (task_code),
    .dq_ready    (dq_ready),
    .task_cancel (task_cancel),
    .settle_busy (settle_busy),
    .task_start  (task_start),
    .irq_n       (irq_n),
    .irq_flag    (irq_flag),
    .scr_hold    (scr_hold)
);

// File: tb/modem_mode_ctrl_tb.sv
module modem_mode_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bit_tick = 1'b0;
    logic [2:0] task_code = '0;
    logic       task_req = 1'b0;
    logic       dq_ready = 1'b0;
    logic       stat_rd = 1'b0;
    logic       tx_in = 1'b0;
    logic       rx_in = 1'b0;
    logic       tx_out, rx_out, tx_mode, pwr_save, scr_hold, task_cancel;
    logic       task_start, settle_busy, irq_flag, dqrdy_flag, irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_tick(bit_tick), .task_code(task_code), .task_req(task_req),
        .dq_ready(dq_ready), .stat_rd(stat_rd), .tx_in(tx_in), .rx_in(rx_in),
        .tx_out(tx_out), .rx_out(rx_out), .tx_mode(tx_mode), .pwr_save(pwr_save),
        .scr_hold(scr_hold), .task_cancel(task_cancel), .task_start(task_start),
        .settle_busy(settle_busy), .irq_flag(irq_flag), .dqrdy_flag(dqrdy_flag),
        .irq_n(irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_mode(input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = val;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic clear_settle();
        tick();
        tick();
    endtask

    task automatic pulse_dq(input logic with_rd);
        dq_ready = 1'b1;
        stat_rd = with_rd;
        @(posedge clk);
        @(negedge clk);
        dq_ready = 1'b0;
        stat_rd = 1'b0;
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tx_in = 1'b1;
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_mode", tx_mode, 1'b0);
        check("R1 pwr_save", pwr_save, 1'b0);
        check("R1 irq_n", irq_n, 1'b1);
        check("R1 settle_busy", settle_busy, 1'b0);
        check("R1 scr_hold", scr_hold, 1'b1);
        check("R1 tx_out", tx_out, 1'b1);
        check("R1 rx_out", rx_out, 1'b0);
        check("R1 irq_flag", irq_flag, 1'b0);
        check("R1 task_cancel", task_cancel, 1'b0);

        // R2 field positions, reserved bits ignored
        task_code = 3'd2;
        for (int b = 2; b < 8; b++) begin
            write_mode(8'(1 << b) | 8'h03);
            check("R2 tx_mode", tx_mode, b == 5);
            check("R2 pwr_save", pwr_save, b == 3);
            check("R2 scr_hold", scr_hold, b != 4);
            check("R2 tx_out", tx_out, (b == 6) ? 1'b0 : 1'b1);
        end
        write_mode(8'h03);
        clear_settle();
        check("R2 rsvd tx_mode", tx_mode, 1'b0);
        check("R2 rsvd pwr_save", pwr_save, 1'b0);
        check("R2 rsvd scr_hold", scr_hold, 1'b1);
        check("R2 rsvd tx_out", tx_out, 1'b1);
        check("R2 rsvd busy", settle_busy, 1'b0);

        // R4 inversion sweep
        for (int inv = 0; inv < 2; inv++) begin
            write_mode(inv[0] ? 8'h40 : 8'h00);
            for (int v = 0; v < 4; v++) begin
                tx_in = v[0];
                rx_in = v[1];
                #1;
                check("R4 tx_out", tx_out, v[0] ^ inv[0]);
                check("R4 rx_out", rx_out, v[1] ^ inv[0]);
            end
        end

        // R5 cancel pulse
        write_mode(8'h00);
        write_mode(8'h20);
        check("R5 cancel on rx->tx", task_cancel, 1'b1);
        @(negedge clk);
        check("R5 cancel one cycle", task_cancel, 1'b0);
        write_mode(8'h20);
        check("R5 no cancel same dir", task_cancel, 1'b0);
        write_mode(8'h00);
        check("R5 cancel on tx->rx", task_cancel, 1'b1);
        clear_settle();

        // R6 / R7 settle window from rx->tx
        task_req = 1'b1;
        #1;
        check("R7 start idle", task_start, 1'b1);
        write_mode(8'h20);
        check("R6 busy after rx->tx", settle_busy, 1'b1);
        check("R7 start held", task_start, 1'b0);
        repeat (3) @(negedge clk);
        check("R6 busy no ticks", settle_busy, 1'b1);
        tick();
        check("R6 busy after 1 tick", settle_busy, 1'b1);
        check("R7 start held 1 tick", task_start, 1'b0);
        tick();
        check("R6 ready after 2 ticks", settle_busy, 1'b0);
        check("R7 start released", task_start, 1'b1);
        write_mode(8'h00);
        check("R6 tx->rx no busy", settle_busy, 1'b0);
        write_mode(8'h08);
        check("R6 enter psave no busy", settle_busy, 1'b0);
        write_mode(8'h00);
        check("R6 leave psave busy", settle_busy, 1'b1);
        tick();
        write_mode(8'h08);
        write_mode(8'h00);
        tick();
        check("R6 retrigger restarts", settle_busy, 1'b1);
        tick();
        check("R6 retrigger ends", settle_busy, 1'b0);
        task_req = 1'b0;
        #1;
        check("R7 no req no start", task_start, 1'b0);

        // R8 scrambler hold sweep
        for (int s = 0; s < 2; s++) begin
            write_mode(s[0] ? 8'h10 : 8'h00);
            for (int c = 0; c < 8; c++) begin
                task_code = 3'(c);
                #1;
                check("R8 scr_hold", scr_hold, !(s[0] && c >= 1 && c <= 3));
            end
        end

        // R9 / R3 flag and pin sweep
        for (int m = 0; m < 8; m++) begin
            logic exp_f;
            write_mode({m[2], 1'b0, m[1], 2'b00, m[0], 2'b00});
            clear_settle();
            read_status();
            pulse_dq(1'b0);
            exp_f = m[0] & ~m[1];
            check("R9 irq_flag", irq_flag, exp_f);
            check("R9 dqrdy_flag", dqrdy_flag, exp_f);
            check("R3 irq_n", irq_n, ~(m[2] & exp_f));
            read_status();
            check("R9 cleared", irq_flag, 1'b0);
            check("R3 irq_n cleared", irq_n, 1'b1);
        end
        write_mode(8'h84);
        pulse_dq(1'b1);
        check("R9 set wins over read", irq_flag, 1'b1);
        check("R3 irq_n low", irq_n, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule